// File: doc/BRIEF.md
# Retention Bin Membership Filter

This block records which DRAM row addresses belong to one retention-time bin. A refresh scheduler asks it whether a candidate row is in the bin. Membership is kept as a probabilistic set in an M-bit flag array, addressed by K independent hash functions of the row address. Loading a bin's contents is done by inserting row addresses one at a time. At refresh time a test returns present or absent. Bits only ever go from 0 to 1, so a row that was inserted is always reported present. An unrelated row may also be reported present if other inserts happen to have set all of its bits. The only way to empty the array is a full clear, used when the bin is reprogrammed.

The K probes are made one per clock through a single hash unit. While they run, `busy_o` is high and new requests are dropped. A test result appears one cycle after its last probe, as a one-cycle pulse. An insert gives no result. If insert and test are raised in the same cycle, the insert runs first and the test follows on the same row.

Top module: `bloom_bin`

## Requirements
- R1: After reset, `busy_o`, `result_valid_o` and `result_present_o` are 0, and a test of any row reports absent.
- R2: Once a row has been inserted, every later test of that row reports present (no false negative).
- R3: A test reports present only when all K hashed bits are 1, so the result equals the AND of those bits in a reference array. `result_present_o` is 0 whenever `result_valid_o` is 0.
- R4: Inserting further rows never turns a present result for an earlier row into absent.
- R5: `clear_i` has priority over every request. It zeroes the whole array, aborts any operation in flight without producing a result, and leaves `busy_o` and `result_valid_o` at 0 in the next cycle.
- R6: A request is accepted at a clock edge where `busy_o` is 0. `busy_o` is then high for exactly K cycles. For a test, `result_valid_o` is high for one cycle, starting at the edge where `busy_o` falls.
- R7: Insert or test strobes raised while `busy_o` is high are ignored. They produce no result and change no array bit.
- R8: Insert and test raised in the same cycle give an insert followed by a test of the same row. `busy_o` stays high for 2K cycles, and the result is present.
- R9: Probe j (0-based, j < K) uses index (y ^ (y >> 16)) mod M. Here y = xs(row ^ ((j+1)·0x9E3779B9 mod 2^32)), and xs applies x ^= x<<13, then x ^= x>>17, then x ^= x<<5, all in 32-bit arithmetic with the row zero-extended. M must be a power of two. 2048/10 and 8192/6 are supported (M/K) settings.
- R10: An insert never raises `result_valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clear_i | input | 1 | Zero the whole array and abort the current operation |
| row_i | input | ADDR_W | Row address for insert or test |
| insert_i | input | 1 | Insert strobe |
| test_i | input | 1 | Test strobe |
| busy_o | output | 1 | Probes in progress; requests are dropped |
| result_valid_o | output | 1 | One-cycle pulse marking a test result |
| result_present_o | output | 1 | Test result: 1 present, 0 absent |

## Verification
The hardest situation to reach from the ports is a false positive. It needs many unrelated rows to have set every one of a probe row's K bits. With a lightly loaded 2048-bit array and ten hashes, such hits almost never occur. The bench therefore inserts several hundred rows, enough that roughly one in five foreign rows collides. It then tests a disjoint address set against its own bit-array model built from the R9 hash. False positives are counted, and the bench confirms that every previously inserted row still reports present.

// File: rtl/bloom_pkg.sv
// Shared definitions for the retention bin filter.
// Assumes 32-bit hash arithmetic; row addresses are at most 32 bits wide.
package bloom_pkg;

    // Operation phase of the probe sequencer.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SET   = 2'd1,
        PH_CHECK = 2'd2
    } phase_e;

    // Seed increment between consecutive hash functions.
    localparam logic [31:0] SEED_STEP = 32'h9E37_79B9;

    // Three-shift xorshift mix of a 32-bit word.
    function automatic logic [31:0] xs_mix(input logic [31:0] x);
        logic [31:0] a;
        logic [31:0] b;
        a = x ^ (x << 13);
        b = a ^ (a >> 17);
        return b ^ (b << 5);
    endfunction

endpackage

// File: rtl/bloom_hash.sv
// Hash unit: maps a row address and a per-probe seed to an array index.
// Assumes ADDR_W <= 32 and M_BITS a power of two; the index is the low
// bits of the folded xorshift result, which equals a modulo by M_BITS.
module bloom_hash #(
    parameter int ADDR_W = 24,
    parameter int M_BITS = 2048,
    localparam int IDX_W = $clog2(M_BITS)
) (
    input  logic [ADDR_W-1:0] row_i,
    input  logic [31:0]       seed_i,
    output logic [IDX_W-1:0]  idx_o
);
    import bloom_pkg::*;

    logic [31:0] row_ext;
    logic [31:0] mixed;
    logic [31:0] folded;

    // Widen the row address to the 32-bit hash word.
    generate
        if (ADDR_W < 32) begin : g_pad
            assign row_ext = {{(32 - ADDR_W){1'b0}}, row_i};
        end else begin : g_full
            assign row_ext = row_i[31:0];
        end
    endgenerate

    // Mix with the seed, fold the halves, keep the index bits.
    always_comb begin
        mixed  = xs_mix(row_ext ^ seed_i);
        folded = mixed ^ (mixed >> 16);
        idx_o  = IDX_W'(folded);
    end

endmodule

// File: rtl/bloom_bitarray.sv
// Flag storage: M_BITS single-bit flags, each set-only until a full clear.
// Assumes one set and one read port share the same index in a cycle.
module bloom_bitarray #(
    parameter int M_BITS = 2048,
    localparam int IDX_W = $clog2(M_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             set_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic             bit_o
);
    logic [M_BITS-1:0] flags_q;

    // Clear wins over set; otherwise set the addressed flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else if (clr_i) begin
            flags_q <= '0;
        end else if (set_i) begin
            flags_q[idx_i] <= 1'b1;
        end
    end

    // Read the addressed flag.
    assign bit_o = flags_q[idx_i];

endmodule

// File: rtl/bloom_seq.sv
// Probe sequencer: accepts insert/test requests when idle, steps through
// K seeds one per cycle, sets flags for inserts and ANDs flags for tests.
// Assumes clear has priority; a simultaneous insert+test defers the test.
module bloom_seq #(
    parameter int ADDR_W = 24,
    parameter int K_HASH = 10,
    localparam int CNT_W = (K_HASH > 1) ? $clog2(K_HASH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              ins_i,
    input  logic              tst_i,
    input  logic [ADDR_W-1:0] row_i,
    input  logic              bit_i,
    output logic [ADDR_W-1:0] row_o,
    output logic [31:0]       seed_o,
    output logic              set_o,
    output logic              busy_o,
    output logic              valid_o,
    output logic              present_o
);
    import bloom_pkg::*;

    localparam logic [CNT_W-1:0] LAST = CNT_W'(K_HASH - 1);

    phase_e            phase_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [31:0]       seed_q;
    logic [ADDR_W-1:0] row_q;
    logic              pend_q;
    logic              acc_q;
    logic              valid_q;
    logic              present_q;
    logic              last_probe;

    assign last_probe = (cnt_q == LAST);

    // Phase, probe counter, seed and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q   <= PH_IDLE;
            cnt_q     <= '0;
            seed_q    <= SEED_STEP;
            row_q     <= '0;
            pend_q    <= 1'b0;
            acc_q     <= 1'b1;
            valid_q   <= 1'b0;
            present_q <= 1'b0;
        end else if (clr_i) begin
            phase_q   <= PH_IDLE;
            cnt_q     <= '0;
            seed_q    <= SEED_STEP;
            pend_q    <= 1'b0;
            acc_q     <= 1'b1;
            valid_q   <= 1'b0;
            present_q <= 1'b0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    valid_q   <= 1'b0;
                    present_q <= 1'b0;
                    cnt_q     <= '0;
                    seed_q    <= SEED_STEP;
                    acc_q     <= 1'b1;
                    if (ins_i) begin
                        phase_q <= PH_SET;
                        row_q   <= row_i;
                        pend_q  <= tst_i;
                    end else if (tst_i) begin
                        phase_q <= PH_CHECK;
                        row_q   <= row_i;
                        pend_q  <= 1'b0;
                    end
                end
                PH_SET: begin
                    if (last_probe) begin
                        cnt_q  <= '0;
                        seed_q <= SEED_STEP;
                        acc_q  <= 1'b1;
                        pend_q <= 1'b0;
                        phase_q <= pend_q ? PH_CHECK : PH_IDLE;
                    end else begin
                        cnt_q  <= cnt_q + CNT_W'(1);
                        seed_q <= seed_q + SEED_STEP;
                    end
                end
                PH_CHECK: begin
                    acc_q <= acc_q & bit_i;
                    if (last_probe) begin
                        valid_q   <= 1'b1;
                        present_q <= acc_q & bit_i;
                        phase_q   <= PH_IDLE;
                    end else begin
                        cnt_q  <= cnt_q + CNT_W'(1);
                        seed_q <= seed_q + SEED_STEP;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // Drive the hash inputs and status outputs.
    assign row_o     = row_q;
    assign seed_o    = seed_q;
    assign set_o     = (phase_q == PH_SET);
    assign busy_o    = (phase_q != PH_IDLE);
    assign valid_o   = valid_q;
    assign present_o = present_q;

endmodule

// File: rtl/bloom_bin.sv
// Top of the retention bin filter: one hash unit, the flag array and the
// serial probe sequencer. Assumes M_BITS is a power of two, ADDR_W <= 32.
module bloom_bin #(
    parameter int ADDR_W = 24,
    parameter int M_BITS = 2048,
    parameter int K_HASH = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic [ADDR_W-1:0] row_i,
    input  logic              insert_i,
    input  logic              test_i,
    output logic              busy_o,
    output logic              result_valid_o,
    output logic              result_present_o
);
    localparam int IDX_W = $clog2(M_BITS);

    logic [ADDR_W-1:0] probe_row;
    logic [31:0]       probe_seed;
    logic [IDX_W-1:0]  probe_idx;
    logic              probe_set;
    logic              probe_bit;

    bloom_seq #(
        .ADDR_W (ADDR_W),
        .K_HASH (K_HASH)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (clear_i),
        .ins_i     (insert_i),
        .tst_i     (test_i),
        .row_i     (row_i),
        .bit_i     (probe_bit),
        .row_o     (probe_row),
        .seed_o    (probe_seed),
        .set_o     (probe_set),
        .busy_o    (busy_o),
        .valid_o   (result_valid_o),
        .present_o (result_present_o)
    );

    bloom_hash #(
        .ADDR_W (ADDR_W),
        .M_BITS (M_BITS)
    ) u_hash (
        .row_i  (probe_row),
        .seed_i (probe_seed),
        .idx_o  (probe_idx)
    );

    bloom_bitarray #(
        .M_BITS (M_BITS)
    ) u_bits (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (clear_i),
        .set_i (probe_set),
        .idx_i (probe_idx),
        .bit_o (probe_bit)
    );

endmodule

// File: rtl/bloom_bin_chk.sv
// Port-level protocol checker for bloom_bin, attached by bind.
// Assumes synchronous active-low reset.
module bloom_bin_chk #(
    parameter int K_HASH = 10
) (
    input logic clk,
    input logic rst_n,
    input logic clear_i,
    input logic insert_i,
    input logic test_i,
    input logic busy_o,
    input logic result_valid_o,
    input logic result_present_o
);
    localparam int RUN_W = $clog2(2 * K_HASH + 2) + 1;
    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(2 * K_HASH);

    logic [RUN_W-1:0] busy_run_q;

    // Length of the current run of busy cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_run_q <= '0;
        end else if (busy_o) begin
            busy_run_q <= busy_run_q + RUN_W'(1);
        end else begin
            busy_run_q <= '0;
        end
    end

    assert_result_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid_o |=> !result_valid_o);

    assert_result_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid_o |-> !busy_o);

    assert_result_after_probe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid_o |-> $past(busy_o));

    assert_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && (insert_i || test_i) && !clear_i) |=> busy_o);

    assert_clear_abort_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (!busy_o && !result_valid_o));

    assert_present_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !result_valid_o |-> !result_present_o);

    // R7, R8: no request can stretch the busy run past two probe passes.
    assert_busy_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_run_q <= RUN_MAX);

endmodule

bind bloom_bin bloom_bin_chk #(
    .K_HASH (K_HASH)
) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .clear_i          (clear_i),
    .insert_i         (insert_i),
    .test_i           (test_i),
    .busy_o           (busy_o),
    .result_valid_o   (result_valid_o),
    .result_present_o (result_present_o)
);

// File: tb/bloom_bin_tb.sv
// Directed bench for bloom_bin with an independent bit-array model.
module bloom_bin_tb;
    localparam int ADDR_W = 24;
    localparam int M_BITS = 2048;
    localparam int K_HASH = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              clear_i = 1'b0;
    logic [ADDR_W-1:0] row_i = '0;
    logic              insert_i = 1'b0;
    logic              test_i = 1'b0;
    logic              busy_o;
    logic              result_valid_o;
    logic              result_present_o;

    int n_cmp = 0;
    int n_bad = 0;
    int n_fp  = 0;
    bit done  = 1'b0;
    bit model [M_BITS];

    always #2.5 clk = ~clk;

    bloom_bin #(.ADDR_W(ADDR_W), .M_BITS(M_BITS), .K_HASH(K_HASH)) u_dut (
        .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .row_i(row_i),
        .insert_i(insert_i), .test_i(test_i), .busy_o(busy_o),
        .result_valid_o(result_valid_o), .result_present_o(result_present_o));

    // Index of probe j for a row, from the R9 formula.
    function automatic int unsigned idx_of(input logic [ADDR_W-1:0] row, input int j);
        logic [31:0] y;
        y = {8'd0, row} ^ (32'h9E3779B9 * (j + 1));
        y = y ^ (y << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return (y ^ (y >> 16)) % M_BITS;
    endfunction

    function automatic bit model_has(input logic [ADDR_W-1:0] row);
        bit all = 1'b1;
        for (int j = 0; j < K_HASH; j++) all &= model[idx_of(row, j)];
        return all;
    endfunction

    task automatic model_add(input logic [ADDR_W-1:0] row);
        for (int j = 0; j < K_HASH; j++) model[idx_of(row, j)] = 1'b1;
    endtask

    task automatic model_wipe();
        for (int i = 0; i < M_BITS; i++) model[i] = 1'b0;
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [ADDR_W-1:0] ins_row(input int i);
        return ADDR_W'(i * 4339 + 7);
    endfunction

    function automatic logic [ADDR_W-1:0] probe_row(input int i);
        return ADDR_W'(32'h80_0000 | (i * 977));
    endfunction

    // Issue one request and follow it until busy falls; sample on negedges.
    task automatic run_op(input bit ins, input bit tst, input logic [ADDR_W-1:0] row,
                          output int cycles, output int valids, output bit present);
        @(negedge clk);
        insert_i = ins; test_i = tst; row_i = row;
        @(negedge clk);
        insert_i = 1'b0; test_i = 1'b0;
        cycles = 0; valids = 0;
        while (busy_o && !done) begin
            cycles++;
            if (result_valid_o) valids++;
            @(negedge clk);
        end
        if (result_valid_o) valids++;
        present = result_present_o;
    endtask

    task automatic do_insert(input logic [ADDR_W-1:0] row);
        int c, v; bit p;
        run_op(1'b1, 1'b0, row, c, v, p);
        chk(c == K_HASH, "R6 insert busy length", c, K_HASH);
        chk(v == 0, "R10 insert gives no result", v, 0);
        model_add(row);
    endtask

    task automatic do_test(input logic [ADDR_W-1:0] row, input bit exp, input string tag);
        int c, v; bit p;
        run_op(1'b0, 1'b1, row, c, v, p);
        chk(c == K_HASH, "R6 test busy length", c, K_HASH);
        chk(v == 1, "R6 one result pulse", v, 1);
        chk(p == exp, tag, p, exp);
    endtask

    task automatic pulse_clear();
        @(negedge clk);
        clear_i = 1'b1;
        @(negedge clk);
        clear_i = 1'b0;
        model_wipe();
    endtask

    // R1: reset state and empty filter.
    task automatic t_reset();
        chk(!busy_o, "R1 busy after reset", busy_o, 0);
        chk(!result_valid_o, "R1 valid after reset", result_valid_o, 0);
        chk(!result_present_o, "R1 present after reset", result_present_o, 0);
        for (int i = 0; i < 3; i++) do_test(probe_row(i + 500), 1'b0, "R1 empty filter absent");
    endtask

    // R2, R10: inserted rows always test present.
    task automatic t_insert_test();
        for (int i = 0; i < 24; i++) do_insert(ins_row(i));
        for (int i = 0; i < 24; i++) do_test(ins_row(i), 1'b1, "R2 inserted row present");
    endtask

    // R3, R9: foreign rows match the model; false positives counted.
    task automatic t_probe(input int base, input int n);
        for (int i = base; i < base + n; i++) begin
            bit e = model_has(probe_row(i));
            if (e) n_fp++;
            do_test(probe_row(i), e, "R3 R9 result matches model");
        end
    endtask

    // R4: heavy fill keeps earlier rows present.
    task automatic t_fill();
        for (int i = 24; i < 400; i++) do_insert(ins_row(i));
        for (int i = 0; i < 24; i++) do_test(ins_row(i), 1'b1, "R4 earlier row still present");
    endtask

    // R7: strobes while busy are dropped.
    task automatic t_busy_drop();
        logic [ADDR_W-1:0] b;
        int c, v;
        b = probe_row(900);
        for (int i = 901; i < 1200 && model_has(b); i++) b = probe_row(i);
        @(negedge clk);
        test_i = 1'b1; row_i = probe_row(3);
        @(negedge clk);
        test_i = 1'b1; insert_i = 1'b1; row_i = b;
        @(negedge clk);
        test_i = 1'b0; insert_i = 1'b0;
        c = 1; v = 0;
        while (busy_o && !done) begin
            c++;
            if (result_valid_o) v++;
            @(negedge clk);
        end
        if (result_valid_o) v++;
        @(negedge clk);
        if (result_valid_o) v++;
        chk(c == K_HASH, "R7 busy length unchanged", c, K_HASH);
        chk(v == 1, "R7 single result", v, 1);
        do_test(b, 1'b0, "R7 dropped insert set no bits");
    endtask

    // R8: simultaneous insert and test.
    task automatic t_both();
        int c, v; bit p;
        logic [ADDR_W-1:0] r;
        r = ins_row(700);
        run_op(1'b1, 1'b1, r, c, v, p);
        chk(c == 2 * K_HASH, "R8 busy covers both passes", c, 2 * K_HASH);
        chk(v == 1, "R8 one result", v, 1);
        chk(p == 1'b1, "R8 deferred test present", p, 1);
        model_add(r);
    endtask

    // R5: full clear and clear during an insert.
    task automatic t_clear();
        logic [ADDR_W-1:0] d;
        int v = 0;
        pulse_clear();
        chk(!busy_o && !result_valid_o, "R5 idle after clear", busy_o, 0);
        for (int i = 0; i < 5; i++) do_test(ins_row(i), 1'b0, "R5 cleared row absent");
        d = ins_row(800);
        @(negedge clk);
        insert_i = 1'b1; row_i = d;
        @(negedge clk);
        insert_i = 1'b0;
        repeat (3) @(negedge clk);
        clear_i = 1'b1;
        @(negedge clk);
        clear_i = 1'b0;
        chk(!busy_o, "R5 clear aborts insert", busy_o, 0);
        repeat (K_HASH) begin
            if (result_valid_o) v++;
            @(negedge clk);
        end
        chk(v == 0, "R5 no result after abort", v, 0);
        do_test(d, 1'b0, "R5 aborted insert left nothing");
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog R6 actual=%0d expected=%0d", 150000, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : main
        model_wipe();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_insert_test();
        t_probe(0, 100);
        t_fill();
        t_probe(100, 200);
        t_busy_drop();
        t_both();
        t_clear();
        $display("false positives observed: %0d", n_fp);
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule